// File: doc/BRIEF.md
# Look-Ahead / Look-Behind Instruction Loop Buffer

This block sits between instruction memory and the decoder. It holds a small sliding window of consecutive instruction words around the current program counter. Entries in front of the counter have been prefetched but not yet handed to decode. Entries behind it have already been issued and are kept on purpose. The decoder pulls one instruction per request. The block keeps the window topped up by reading sequential addresses from memory, with one read in flight at a time.

A redirect port carries a branch target. When the target lies inside the buffered window, the counter moves there and decode continues from stored words without touching memory. This is the case for the backward branch that closes a short loop. When the target lies outside the window, the window is emptied and fetching restarts at the target.

The window is a circular array tagged with the address of its oldest entry. Once the array is full, a new fetch overwrites the oldest already-issued entry. Prefetch stops rather than shrink the issued history below a configured minimum depth.

Top module: `loop_buffer`

## Requirements
- R1: After reset, `dec_valid`, `redir_hit` and `mem_req` are 0. On the first clock edge after reset is released, a read of address `RESET_PC` is issued.
- R2: Instructions are delivered in ascending address order from the current counter, one per served request. `dec_valid` rises on the cycle after the request is taken, with `dec_pc` equal to the address and `dec_instr` equal to the word memory returned for that address.
- R3: While no prefetched entry lies ahead of the counter, a decode request is not served and `dec_valid` stays 0.
- R4: A redirect whose target lies in [oldest address, oldest address + valid entries) is a hit. `redir_hit` is 1 on the following cycle, and the target instruction is delivered from the buffer with no memory read at or below the window's end.
- R5: A redirect outside that range is a miss. `redir_hit` is 0, the buffer is emptied, and the target is fetched from memory and delivered next.
- R6: A read in flight when a redirect arrives is discarded: its data never reaches decode, and the next delivered instruction is the redirect target's.
- R7: A redirect takes precedence over a decode request in the same cycle; no instruction is delivered on the following cycle.
- R8: A loop whose body has at most `MIN_BEHIND` instructions repeats, once executed, with every closing branch a hit and no further memory reads of the loop body.
- R9: With no redirect, the buffer fills to `DEPTH` entries. After k instructions have been issued, it performs exactly `DEPTH + max(0, k - MIN_BEHIND)` reads and then stops. At most one read is in flight at a time.
- R10: A fill into a full buffer overwrites the oldest entry and advances the oldest address by one. After it, a redirect to the overwritten address misses and a redirect to the next address hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_req | input | 1 | Decoder asks for the next instruction |
| dec_valid | output | 1 | An instruction is delivered this cycle |
| dec_pc | output | AW | Address of the delivered instruction |
| dec_instr | output | IW | Delivered instruction word |
| redir_valid | input | 1 | Branch redirect strobe |
| redir_target | input | AW | Branch target address |
| redir_hit | output | 1 | Previous-cycle redirect was served from the window |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | AW | Read address |
| mem_rsp_valid | input | 1 | Read data returns this cycle |
| mem_rsp_data | input | IW | Returned instruction word |

## Verification
The bench sweeps the number of issued instructions from zero to the full depth. For each count it tries every redirect target from one below the oldest retained address to one past the newest. An off-by-one in the range compare shows up as a wrong `redir_hit` at either edge. A design that evicted too eagerly, or never evicted, would show up as a wrong number of reads before prefetch goes idle. Back-to-back redirects while a read is outstanding target the case where stale memory data slips into the window and is delivered under the new target's address. A short loop run several times checks that the look-behind history survives prefetch and that no loop address is read again.

// File: rtl/lb_pkg.sv
package lb_pkg;
  // How a redirect is classified against the buffered window
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_HIT  = 2'd1,
    RD_MISS = 2'd2
  } redir_kind_e;
endpackage

// File: rtl/lb_store.sv
// Entry storage: one write port (fill), one registered read port (decode).
module lb_store #(
  parameter int IW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [IW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [IW-1:0]            rdata
);
  logic [IW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/lb_window.sv
// Window bookkeeping: oldest address, ring head, valid count, issue offset.
// DEPTH must be a power of two so slot indices wrap naturally.
module lb_window
  import lb_pkg::*;
#(
  parameter int             AW         = 16,
  parameter int             DEPTH      = 8,
  parameter int             MIN_BEHIND = 4,
  parameter logic [AW-1:0]  RESET_PC   = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dec_req,
  input  logic                     redir_valid,
  input  logic [AW-1:0]            redir_target,
  input  logic                     fill_valid,
  output logic                     serve,
  output logic [$clog2(DEPTH)-1:0] rd_slot,
  output logic [AW-1:0]            rd_pc,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_slot,
  output logic                     can_fill,
  output logic [AW-1:0]            fill_addr,
  output logic                     hit_now
);
  localparam int IDX = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);

  logic [AW-1:0]  base_q;   // address of oldest entry
  logic [IDX-1:0] head_q;   // slot of oldest entry
  logic [CW-1:0]  cnt_q;    // valid entries
  logic [CW-1:0]  off_q;    // issued entries (look-behind depth)

  logic [AW-1:0]  diff;
  redir_kind_e    kind;
  logic           full, evict_ok, evict;

  always_comb begin
    diff = redir_target - base_q;
    if (!redir_valid)              kind = RD_NONE;
    else if (diff < AW'(cnt_q))    kind = RD_HIT;
    else                           kind = RD_MISS;
  end

  assign full      = (cnt_q == CW'(DEPTH));
  assign evict_ok  = (off_q > CW'(MIN_BEHIND));
  assign can_fill  = !full || evict_ok;
  assign serve     = dec_req && (kind == RD_NONE) && (off_q < cnt_q);
  assign wr_en     = fill_valid && can_fill;
  assign evict     = wr_en && full;
  assign rd_slot   = head_q + off_q[IDX-1:0];
  assign wr_slot   = head_q + cnt_q[IDX-1:0];
  assign rd_pc     = base_q + AW'(off_q);
  assign fill_addr = base_q + AW'(cnt_q);
  assign hit_now   = (kind == RD_HIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= RESET_PC;
      head_q <= '0;
      cnt_q  <= '0;
      off_q  <= '0;
    end else begin
      case (kind)
        RD_HIT: off_q <= diff[CW-1:0];
        RD_MISS: begin
          base_q <= redir_target;
          head_q <= '0;
          cnt_q  <= '0;
          off_q  <= '0;
        end
        default: begin
          if (wr_en && !full) cnt_q <= cnt_q + 1'b1;
          if (evict) begin
            base_q <= base_q + 1'b1;
            head_q <= head_q + 1'b1;
          end
          off_q <= off_q + CW'(serve) - CW'(evict);
        end
      endcase
    end
  end

  // R10
  evict_floor_chk: assert property (@(posedge clk) disable iff (rst)
    evict |=> (off_q >= CW'(MIN_BEHIND)));
  // R5
  miss_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == RD_MISS) |=> (cnt_q == '0 && off_q == '0 && base_q == $past(redir_target)));
  // R4
  hit_keeps_window_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == RD_HIT) |=> (cnt_q == $past(cnt_q) && base_q == $past(base_q)));
  // R3
  off_bound_chk: assert property (@(posedge clk) disable iff (rst)
    off_q <= cnt_q);
endmodule

// File: rtl/lb_fetch.sv
// Sequential prefetch with a single outstanding read; drops stale returns.
module lb_fetch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redir_valid,
  input  logic          can_fill,
  input  logic [AW-1:0] fill_addr,
  input  logic          mem_rsp_valid,
  output logic          fill_valid,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr
);
  logic pending_q, stale_q, issue;

  assign issue      = !pending_q && !redir_valid && can_fill;
  assign fill_valid = mem_rsp_valid && pending_q && !stale_q && !redir_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      stale_q   <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
    end else begin
      mem_req <= issue;
      if (issue) mem_addr <= fill_addr;
      if (mem_rsp_valid) begin
        pending_q <= 1'b0;
        stale_q   <= 1'b0;
      end else begin
        if (issue) pending_q <= 1'b1;
        if (redir_valid && pending_q) stale_q <= 1'b1;
      end
    end
  end

  // R9
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
endmodule

// File: rtl/loop_buffer.sv
module loop_buffer #(
  parameter int            AW         = 16,
  parameter int            IW         = 32,
  parameter int            DEPTH      = 8,
  parameter int            MIN_BEHIND = 4,
  parameter logic [AW-1:0] RESET_PC   = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_req,
  output logic          dec_valid,
  output logic [AW-1:0] dec_pc,
  output logic [IW-1:0] dec_instr,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_target,
  output logic          redir_hit,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [IW-1:0] mem_rsp_data
);
  localparam int IDX = $clog2(DEPTH);

  logic           serve, wr_en, can_fill, hit_now, fill_valid;
  logic [IDX-1:0] rd_slot, wr_slot;
  logic [AW-1:0]  rd_pc, fill_addr;

  lb_window #(.AW(AW), .DEPTH(DEPTH), .MIN_BEHIND(MIN_BEHIND), .RESET_PC(RESET_PC)) u_win (
    .clk(clk), .rst(rst), .dec_req(dec_req), .redir_valid(redir_valid),
    .redir_target(redir_target), .fill_valid(fill_valid), .serve(serve),
    .rd_slot(rd_slot), .rd_pc(rd_pc), .wr_en(wr_en), .wr_slot(wr_slot),
    .can_fill(can_fill), .fill_addr(fill_addr), .hit_now(hit_now)
  );

  lb_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .redir_valid(redir_valid), .can_fill(can_fill),
    .fill_addr(fill_addr), .mem_rsp_valid(mem_rsp_valid), .fill_valid(fill_valid),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );

  lb_store #(.IW(IW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_slot), .wdata(mem_rsp_data),
    .re(serve), .raddr(rd_slot), .rdata(dec_instr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_pc    <= '0;
      redir_hit <= 1'b0;
    end else begin
      dec_valid <= serve;
      if (serve) dec_pc <= rd_pc;
      redir_hit <= hit_now;
    end
  end

  // R7
  redirect_blocks_decode_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !dec_valid);
endmodule

// File: tb/loop_buffer_test.sv
module loop_buffer_test;
  localparam int CLK_P = 10;
  localparam int AW = 16, IW = 32, DEPTH = 8, MINB = 4, LAT = 3;

  logic clk = 0, rst = 1, dec_req = 0, redir_valid = 0;
  logic [AW-1:0] redir_target = '0;
  logic dec_valid, redir_hit, mem_req, mem_rsp_valid;
  logic [AW-1:0] dec_pc, mem_addr;
  logic [IW-1:0] dec_instr, mem_rsp_data;

  int nchk = 0, nfail = 0, cyc = 0;
  int reqs = 0, lowreqs = 0, snap_req = 0;
  logic [AW-1:0] whi = '0;

  always #(CLK_P/2) clk = ~clk;

  loop_buffer #(.AW(AW), .IW(IW), .DEPTH(DEPTH), .MIN_BEHIND(MINB)) uut (
    .clk(clk), .rst(rst), .dec_req(dec_req), .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_instr(dec_instr), .redir_valid(redir_valid), .redir_target(redir_target),
    .redir_hit(redir_hit), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [IW-1:0] word_at(input logic [AW-1:0] a);
    return {a ^ 16'hC3A5, a};
  endfunction

  // memory model: fixed latency LAT
  logic          pv [LAT];
  logic [AW-1:0] pa [LAT];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
    end else begin
      pv[0] <= mem_req; pa[0] <= mem_addr;
      for (int i = 1; i < LAT; i++) begin pv[i] <= pv[i-1]; pa[i] <= pa[i-1]; end
      if (mem_req) reqs <= reqs + 1;
      if (mem_req && mem_addr < whi) lowreqs <= lowreqs + 1;
    end
  end
  assign mem_rsp_valid = pv[LAT-1];
  assign mem_rsp_data  = word_at(pa[LAT-1]);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic redirect(input logic [AW-1:0] t, output bit hit);
    redir_valid = 1; redir_target = t;
    step();
    redir_valid = 0;
    hit = redir_hit;
    snap_req = reqs;
  endtask

  task automatic get_instr(input logic [AW-1:0] pc, input string tag);
    int w;
    dec_req = 1; w = 0;
    step();
    while (!dec_valid && w < 200) begin step(); w++; end
    dec_req = 0;
    chk(dec_valid, {tag, " valid"}, 32'(dec_valid), 1);
    chk(dec_pc == pc, {tag, " pc"}, 32'(dec_pc), 32'(pc));
    chk(dec_instr == word_at(pc), {tag, " data"}, dec_instr, word_at(pc));
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    bit h;
    int n, F, lsnap;
    logic [AW-1:0] st, bse, t;
    repeat (5) step();
    rst = 0;
    // R1: reset state, then first fetch at RESET_PC
    chk(!dec_valid && !redir_hit && !mem_req, "R1 reset outputs",
        {29'd0, dec_valid, redir_hit, mem_req}, 0);
    step();
    chk(mem_req && mem_addr == 0, "R1 first fetch", {15'd0, mem_req, mem_addr}, 32'h0001_0000);

    // R2: sequential delivery with irregular request gaps
    for (int i = 0; i < 20; i++) begin
      get_instr(AW'(i), "R2");
      if (i % 3 == 2) repeat (2) step();
    end

    // R3: miss leaves nothing ahead; requests stall
    redirect(16'd300, h);
    chk(!h, "R5 miss flag", 32'(h), 0);
    dec_req = 1;
    step();
    chk(!dec_valid, "R3 stall 1", 32'(dec_valid), 0);
    step(); step();
    chk(!dec_valid, "R3 stall 3", 32'(dec_valid), 0);
    get_instr(16'd300, "R3/R5");
    get_instr(16'd301, "R2");

    // R7: redirect and decode request together
    repeat (20) step();
    dec_req = 1;
    redirect(16'd301, h);
    chk(!dec_valid, "R7 no delivery", 32'(dec_valid), 0);
    chk(h, "R4 hit flag", 32'(h), 1);
    dec_req = 0;
    get_instr(16'd301, "R7");

    // R6: back-to-back redirects with a read in flight
    redirect(16'd500, h);
    redirect(16'd600, h);
    for (int i = 0; i < 6; i++) get_instr(AW'(600 + i), "R6");

    // R8: loop of MINB instructions repeats from the buffer
    redirect(16'd700, h);
    for (int i = 0; i < MINB; i++) get_instr(AW'(700 + i), "R8");
    whi = AW'(700 + MINB);
    step();
    lsnap = lowreqs;
    for (int it = 0; it < 6; it++) begin
      redirect(16'd700, h);
      chk(h, "R8 loop hit", 32'(h), 1);
      for (int i = 0; i < MINB; i++) get_instr(AW'(700 + i), "R8");
    end
    step();
    chk(lowreqs == lsnap, "R8 no refetch", 32'(lowreqs - lsnap), 0);

    // R9/R10/R4/R5 sweep: issued count k, then every target around the window
    n = 0;
    for (int k = 0; k <= DEPTH; k++) begin
      F = DEPTH + ((k > MINB) ? (k - MINB) : 0);
      for (int o = -1; o <= DEPTH + 1; o++) begin
        st  = AW'(1000 + 32 * n); n++;
        bse = st + AW'(F - DEPTH);
        t   = bse + AW'(o);
        if (o > DEPTH) t = st + AW'(F);
        whi = '0;
        redirect(st, h);
        chk(!h, "R5 sweep miss", 32'(h), 0);
        for (int j = 0; j < k; j++) get_instr(st + AW'(j), "R2 sweep");
        repeat (100) step();
        chk(reqs - snap_req == F, "R9 fill count", 32'(reqs - snap_req), 32'(F));
        whi = st + AW'(F);
        step();
        lsnap = lowreqs;
        redirect(t, h);
        chk(h == (t >= bse && t < st + AW'(F)), "R10 hit range", 32'(h),
            32'(t >= bse && t < st + AW'(F)));
        get_instr(t, h ? "R4" : "R5");
        if (h) chk(lowreqs == lsnap, "R4 no memory read", 32'(lowreqs - lsnap), 0);
        whi = '0;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule